// File: doc/BRIEF.md
# Dual-Mode Converter Configuration Port

This block is the mode-control front end of a data converter. Three control pins (a chip select, a clock and a data line) serve one of two purposes. A static strap input picks which one. With the strap low, the pins form a serial port. A host writes a small bank of 8-bit mode registers through it and reads them back. Read data leaves on an output modelled as open drain: an enable that pulls the line low for a 0 bit and otherwise releases it. With the strap high, each pin directly sets one converter function by its level: the clock duty-cycle stabilizer, the output format and sleep.

All three pins are brought into the block's clock domain through two-flop synchronizers. Serial clock edges are found from the synchronized levels, so the serial clock must run well below the block clock. The three decoded control outputs come from register 1 in serial mode and from the synchronized pin levels in parallel mode.

Top module: `cfg_port`

## Requirements
- R1: Strap `par_mode` low selects serial mode, where the control outputs follow register 1 whatever the pin levels. Strap high selects parallel mode, where the pins act as levels and no register changes. The strap is only changed while reset is held.
- R2: In serial mode, serial clock edges are ignored while chip select is high. Chip select high also clears any frame in progress.
- R3: In serial mode, the data pin is sampled on the rising edge of the serial clock. Changes on it while the clock is high have no effect.
- R4: A frame is 16 bits, MSB first: bit 15 is the read flag (1 = read, 0 = write), bits 14..8 are the register address and bits 7..0 are the data. After the 8th rising edge of a read, the addressed register is presented MSB first. The host latches one bit at each falling edge that follows rising edges 8 through 15.
- R5: `sdo_pull` is asserted only for a 0 readback bit in serial mode while chip select is low. It is never asserted in parallel mode.
- R6: In parallel mode, chip select low turns the stabilizer output `dcs_on` off, and chip select high turns it on.
- R7: In parallel mode, serial clock low selects full-rate CMOS format (`fmt_ddr`=0), and serial clock high selects double-data-rate LVDS format (`fmt_ddr`=1).
- R8: In parallel mode, the data pin low gives normal operation (`sleep`=0), and the data pin high gives `sleep`=1.
- R9: A write commits at its 16th rising edge with chip select still low. In register 1, bit 2 drives `dcs_on`, bit 1 drives `fmt_ddr` and bit 0 drives `sleep`. Extra edges beyond 16 in the same frame are ignored.
- R10: If chip select rises before the 16th rising edge, the frame is discarded and no register changes.
- R11: Reset clears every register to zero, so the stabilizer is off, the format is CMOS and the part is not asleep. A write with data bit 7 set to address 0 clears every register.
- R12: Writes to an address at or above NREGS are dropped, and reads of such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | Static strap: 0 serial, 1 parallel |
| pin_cs_n | input | 1 | Chip select / stabilizer level |
| pin_sck | input | 1 | Serial clock / format level |
| pin_sdi | input | 1 | Serial data / sleep level |
| sdo_pull | output | 1 | Pull serial data output low |
| dcs_on | output | 1 | Duty-cycle stabilizer enable |
| fmt_ddr | output | 1 | 1 = DDR LVDS, 0 = full-rate CMOS |
| sleep | output | 1 | Sleep request |

## Verification
In parallel mode the bench sweeps all eight pin-level combinations. This shows that each output follows its own pin and is not swapped with another. In serial mode it writes every 8-bit value to a spare register and reads each one back. This separates errors in bit order, shift alignment and open-drain polarity. Further frames are cut short, lengthened, sent with the data pin toggling while the clock is high, sent with clock pulses while chip select is high, and sent to out-of-range addresses. Each of these shows whether the sampling edge, the commit point and the frame-discard rules hold.

// File: rtl/cfg_port.sv
module cfg_port #(
  parameter int NREGS = 4,
  parameter int DW    = 8,
  parameter int AW    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic par_mode,
  input  logic pin_cs_n,
  input  logic pin_sck,
  input  logic pin_sdi,
  output logic sdo_pull,
  output logic dcs_on,
  output logic fmt_ddr,
  output logic sleep
);
  localparam int FW = 1 + AW + DW;
  localparam int CW = $clog2(FW + 1);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [1:0] cs_q, sck_q, sdi_q;
  logic       sck_d;
  logic [CW-1:0] cnt;
  logic [FW-2:0] sh;
  logic [DW-1:0] rd_sh;
  logic          rd_act;
  logic [DW-1:0] regs [NREGS];
  logic [NREGS*DW-1:0] regs_flat;

  wire cs_s  = cs_q[1];
  wire sck_s = sck_q[1];
  wire sdi_s = sdi_q[1];
  wire rise  = sck_s & ~sck_d & ~cs_s & ~par_mode;

  wire [AW:0]    hdr    = {sh[AW-1:0], sdi_s};
  wire [FW-1:0]  word   = {sh, sdi_s};
  wire [AW-1:0]  waddr  = word[FW-2:DW];
  wire [DW-1:0]  wdata  = word[DW-1:0];
  wire           last   = (cnt == CW'(FW - 1));
  wire           commit = rise & last & ~word[FW-1];

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (32'(hdr[AW-1:0]) < NREGS) rd_val = regs[hdr[IW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 2'b11; sck_q <= '0; sdi_q <= '0; sck_d <= 1'b0;
    end else begin
      cs_q  <= {cs_q[0], pin_cs_n};
      sck_q <= {sck_q[0], pin_sck};
      sdi_q <= {sdi_q[0], pin_sdi};
      sck_d <= sck_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sh <= '0; rd_sh <= '0; rd_act <= 1'b0;
    end else if (cs_s || par_mode) begin
      cnt <= '0; rd_act <= 1'b0;
    end else if (rise && cnt != CW'(FW)) begin
      cnt <= cnt + 1'b1;
      sh  <= {sh[FW-3:0], sdi_s};
      if (cnt == CW'(AW) && hdr[AW]) begin
        rd_act <= 1'b1;
        rd_sh  <= rd_val;
      end else if (rd_act) begin
        if (last) rd_act <= 1'b0;
        else      rd_sh  <= {rd_sh[DW-2:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (commit) begin
      if (waddr == '0 && wdata[DW-1]) begin
        for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (32'(waddr) < NREGS) begin
        regs[waddr[IW-1:0]] <= wdata;
      end
    end

  always_comb
    for (int i = 0; i < NREGS; i++) regs_flat[i*DW +: DW] = regs[i];

  assign sdo_pull = rd_act & ~rd_sh[DW-1];
  assign dcs_on   = par_mode ? cs_s  : regs[1][2];
  assign fmt_ddr  = par_mode ? sck_s : regs[1][1];
  assign sleep    = par_mode ? sdi_s : regs[1][0];

  assert_no_pull_parallel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> !sdo_pull);
  assert_no_pull_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !sdo_pull);
  assert_regs_frozen_parallel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> $stable(regs_flat));
  assert_commit_only_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && last) |=> $stable(regs_flat));
  assert_deselect_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0));
  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FW));
endmodule

// File: tb/tb_cfg_port.sv
module tb_cfg_port;
  logic clk = 0, rst_n = 0, par_mode = 0, cs_n = 1, sck = 0, sdi = 0;
  logic sdo_pull, dcs_on, fmt_ddr, sleep;
  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] rb;

  always #10 clk = ~clk;

  cfg_port dut (.clk(clk), .rst_n(rst_n), .par_mode(par_mode), .pin_cs_n(cs_n),
    .pin_sck(sck), .pin_sdi(sdi), .sdo_pull(sdo_pull), .dcs_on(dcs_on),
    .fmt_ddr(fmt_ddr), .sleep(sleep));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit wiggle,
                       output logic [7:0] rd);
    rd = '0;
    cs_n = 0; clks(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15 - (i % 16)] : 1'b1;
      clks(4);
      sck = 1; clks(2);
      if (wiggle) sdi = ~sdi;
      clks(2);
      if (i >= 7 && i <= 14) rd[14 - i] = ~sdo_pull;
      sck = 0;
    end
    clks(4);
    cs_n = 1; sdi = 0; clks(6);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] x;
    frame({1'b0, a, d}, 16, 0, x);
  endtask

  task automatic rdr(input logic [6:0] a, output logic [7:0] d);
    frame({1'b1, a, 8'h00}, 16, 0, d);
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 0; par_mode = mode; cs_n = 1; sck = 0; sdi = 0;
    clks(3); rst_n = 1; clks(3);
  endtask

  initial begin
    do_reset(0);
    check("R11 reset dcs", dcs_on, 0);
    check("R11 reset fmt", fmt_ddr, 0);
    check("R11 reset sleep", sleep, 0);
    for (int a = 0; a < 4; a++) begin
      rdr(7'(a), rb); check("R11 reset reg", rb, 0);
    end
    check("R1 serial ignores pin levels", dcs_on, 0);

    for (int v = 0; v < 256; v++) begin
      wr(7'd2, 8'(v)); rdr(7'd2, rb); check("R4 readback sweep", rb, v);
    end

    for (int v = 0; v < 8; v++) begin
      wr(7'd1, 8'(v));
      check("R9 dcs bit2", dcs_on, (v >> 2) & 1);
      check("R9 fmt bit1", fmt_ddr, (v >> 1) & 1);
      check("R9 sleep bit0", sleep, v & 1);
    end

    wr(7'd1, 8'h05);
    frame({1'b0, 7'd1, 8'hFF}, 15, 0, rb);
    rdr(7'd1, rb); check("R10 partial discarded", rb, 8'h05);
    check("R10 outputs unchanged", {dcs_on, fmt_ddr, sleep}, 3'b101);

    for (int k = 0; k < 20; k++) begin
      sdi = 1; clks(3); sck = 1; clks(4); check("R5 no pull deselected", sdo_pull, 0); sck = 0; clks(3);
    end
    sdi = 0;
    rdr(7'd1, rb); check("R2 clocks ignored while deselected", rb, 8'h05);
    wr(7'd3, 8'hA6); rdr(7'd3, rb); check("R2 framing intact after idle clocks", rb, 8'hA6);

    frame({1'b0, 7'd3, 8'h3C}, 16, 1, rb);
    rdr(7'd3, rb); check("R3 sampled at rising edge", rb, 8'h3C);

    frame({1'b0, 7'd2, 8'h81}, 20, 0, rb);
    rdr(7'd2, rb); check("R9 extra edges ignored", rb, 8'h81);

    wr(7'd5, 8'hFF); rdr(7'd5, rb); check("R12 out of range read", rb, 0);
    rdr(7'd1, rb); check("R12 reg1 untouched", rb, 8'h05);
    rdr(7'd2, rb); check("R12 reg2 untouched", rb, 8'h81);

    wr(7'd0, 8'h80);
    for (int a = 0; a < 4; a++) begin
      rdr(7'(a), rb); check("R11 soft reset clears", rb, 0);
    end
    check("R11 soft reset outputs", {dcs_on, fmt_ddr, sleep}, 3'b000);

    do_reset(1);
    for (int p = 0; p < 8; p++) begin
      cs_n = p[2]; sck = p[1]; sdi = p[0]; clks(5);
      check("R6 par dcs follows cs", dcs_on, p[2]);
      check("R7 par fmt follows sck", fmt_ddr, p[1]);
      check("R8 par sleep follows sdi", sleep, p[0]);
      check("R5 par never pulls", sdo_pull, 0);
    end
    cs_n = 1; sck = 0; sdi = 0; clks(4);
    frame({1'b1, 7'd2, 8'h00}, 16, 0, rb);
    check("R1 parallel no serial readback", rb, 8'hFF);
    do_reset(0);
    rdr(7'd2, rb); check("R1 back to serial", rb, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule